// File: doc/BRIEF.md
# Nine-Bit Stored-Program Sequencer

This block is a very small processor that runs a program of up to eight 9-bit words held in its own program store. Each word is split into three 3-bit fields: the operation in the top field, and two operand fields below it. The machine steps through a fetch phase and then an execute phase for every instruction. It keeps a 3-bit program counter, an instruction register and eight 8-bit working registers.

Software or a test harness first writes the program through a load port and then pulses `start`. The machine then runs until it executes a stop word, and after that it holds `halted` high. Results are read back one register at a time through a registered read port. The operations are: load a small constant, add one register into another, count a register down by a constant, jump when a register is nonzero, and stop. A loop built from these operations multiplies two 3-bit numbers by repeated addition.

Top module: `tiny_seq_cpu`

## Requirements
- R1: A word is laid out as op = bits [8:6], a = bits [5:3], b = bits [2:0]. When op = 000 (load constant), register b receives the value a, zero-extended to 8 bits.
- R2: When op = 001 (accumulate), register b receives register a plus register b, modulo 256.
- R3: When op = 010 (count down), register a receives register a minus the constant b, modulo 256.
- R4: When op = 011 (jump if nonzero), the program counter becomes b if register a is nonzero. Otherwise it becomes PC+1.
- R5: When op = 100 (stop), `halted` rises and stays high until reset. No register or counter changes after that, and `start` is ignored.
- R6: Every instruction takes exactly two clock cycles, one to fetch and one to execute. Every executed word other than a taken jump or a stop advances the program counter by one, and the counter wraps from 7 to 0.
- R7: Opcodes 101, 110 and 111 write no register and only advance the program counter.
- R8: Reset clears all registers, sets the program counter to 0 and drops `halted`. The machine then waits, doing nothing, until `start` is seen high.
- R9: `rd_data` shows register `rd_sel` one clock cycle after `rd_sel` is presented.
- R10: A cycle with `load_en` high writes `load_data` into program location `load_addr`. Other locations keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins execution from an idle machine |
| load_en | input | 1 | Program store write enable |
| load_addr | input | 3 | Program store write location |
| load_data | input | 9 | Instruction word to write |
| rd_sel | input | 3 | Register selected for read-back |
| rd_data | output | 8 | Registered read-back value |
| halted | output | 1 | High once a stop word has executed |

## Verification
The bench runs the multiply-by-repeated-addition program for every pair of 3-bit factors. This includes a zero count, which underflows to 255 and loops 256 times; a design that tested for zero before it decremented, or that saturated, would give a product other than zero and a different cycle total. The number of clock edges from `start` to `halted` is checked against two cycles per instruction, so an extra or a missing phase shows up. A separate program makes a jump that is first not taken, then taken, across the 7-to-0 wrap of the program counter. A counter that saturated or took the wrong target would never reach the stop word. Further programs check that the unused opcodes write nothing, that a second `start` after stop changes nothing, that doubling overflows modulo 256, and that a single-word reload changes only that word.

// File: rtl/tiny_cpu_pkg.sv
package tiny_cpu_pkg;
  localparam logic [2:0] OP_LDC  = 3'd0;
  localparam logic [2:0] OP_ACC  = 3'd1;
  localparam logic [2:0] OP_DEC  = 3'd2;
  localparam logic [2:0] OP_JNZ  = 3'd3;
  localparam logic [2:0] OP_STOP = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_HALT  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tcpu_prog_mem.sv
module tcpu_prog_mem #(
  parameter int AW = 3,
  parameter int IW = 9
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [IW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [IW-1:0] rd_q
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Registered read port; its output register is the instruction register.
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/tcpu_reg_file.sv
module tcpu_reg_file #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic [AW-1:0] rd_sel,
  output logic [DW-1:0] rd_q
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= regs[rd_sel];
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
endmodule

// File: rtl/tcpu_exec_unit.sv
module tcpu_exec_unit
  import tiny_cpu_pkg::*;
#(
  parameter int FW = 3,
  parameter int DW = 8
) (
  input  logic            en,
  input  logic [3*FW-1:0] instr,
  input  logic [DW-1:0]   va,
  input  logic [DW-1:0]   vb,
  output logic            we,
  output logic [FW-1:0]   waddr,
  output logic [DW-1:0]   wdata,
  output logic            br_take,
  output logic            is_stop
);
  logic [FW-1:0] op, fa, fb;

  assign op = instr[3*FW-1 -: FW];
  assign fa = instr[2*FW-1 -: FW];
  assign fb = instr[FW-1:0];

  always_comb begin
    we      = 1'b0;
    waddr   = fb;
    wdata   = '0;
    br_take = 1'b0;
    is_stop = 1'b0;
    unique case (op)
      OP_LDC: begin
        we    = en;
        wdata = DW'(fa);
      end
      OP_ACC: begin
        we    = en;
        wdata = va + vb;
      end
      OP_DEC: begin
        we    = en;
        waddr = fa;
        wdata = va - DW'(fb);
      end
      OP_JNZ:  br_take = en && (va != '0);
      OP_STOP: is_stop = en;
      default: ;
    endcase
  end
endmodule

// File: rtl/tcpu_sequencer.sv
module tcpu_sequencer
  import tiny_cpu_pkg::*;
#(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          br_take,
  input  logic          is_stop,
  input  logic [FW-1:0] br_target,
  output logic          fetch_en,
  output logic          exec_en,
  output logic [FW-1:0] pc,
  output logic          halted,
  output seq_state_t    state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      pc     <= '0;
      halted <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (start) state <= ST_FETCH;
        ST_FETCH: state <= ST_EXEC;
        ST_EXEC: begin
          if (is_stop) begin
            state  <= ST_HALT;
            halted <= 1'b1;
          end else begin
            state <= ST_FETCH;
            pc    <= br_take ? br_target : pc + 1'b1;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign fetch_en = (state == ST_FETCH);
  assign exec_en  = (state == ST_EXEC);
endmodule

// File: rtl/tiny_seq_cpu.sv
module tiny_seq_cpu
  import tiny_cpu_pkg::*;
#(
  parameter int FW = 3,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            load_en,
  input  logic [FW-1:0]   load_addr,
  input  logic [3*FW-1:0] load_data,
  input  logic [FW-1:0]   rd_sel,
  output logic [DW-1:0]   rd_data,
  output logic            halted
);
  localparam int IW = 3 * FW;

  logic [IW-1:0] ir;
  logic [FW-1:0] pc;
  logic          fetch_en, exec_en;
  logic          rf_we, br_take, is_stop;
  logic [FW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, ra_data, rb_data;
  seq_state_t    st;

  tcpu_prog_mem #(.AW(FW), .IW(IW)) u_mem (
    .clk     (clk),
    .wr_en   (load_en),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_en   (fetch_en),
    .rd_addr (pc),
    .rd_q    (ir)
  );

  tcpu_reg_file #(.AW(FW), .DW(DW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .ra_addr (ir[2*FW-1 -: FW]),
    .ra_data (ra_data),
    .rb_addr (ir[FW-1:0]),
    .rb_data (rb_data),
    .rd_sel  (rd_sel),
    .rd_q    (rd_data)
  );

  tcpu_exec_unit #(.FW(FW), .DW(DW)) u_exec (
    .en      (exec_en),
    .instr   (ir),
    .va      (ra_data),
    .vb      (rb_data),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .br_take (br_take),
    .is_stop (is_stop)
  );

  tcpu_sequencer #(.FW(FW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .br_take   (br_take),
    .is_stop   (is_stop),
    .br_target (ir[FW-1:0]),
    .fetch_en  (fetch_en),
    .exec_en   (exec_en),
    .pc        (pc),
    .halted    (halted),
    .state     (st)
  );
endmodule

// File: rtl/tcpu_checker.sv
module tcpu_checker
  import tiny_cpu_pkg::*;
#(
  parameter int FW = 3,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            halted,
  input seq_state_t      state,
  input logic [FW-1:0]   pc,
  input logic [3*FW-1:0] ir,
  input logic [DW-1:0]   a_val
);
  logic [FW-1:0] op;
  assign op = ir[3*FW-1 -: FW];

  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r5_halt_pc_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  a_r6_fetch_then_exec: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH) |=> (state == ST_EXEC));

  a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op != OP_JNZ && op != OP_STOP)
      |=> (pc == FW'($past(pc) + 1'b1)));

  a_r4_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && op == OP_JNZ && a_val != '0)
      |=> (pc == $past(ir[FW-1:0])));

  a_r8_idle_wait: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> (state == ST_IDLE));
endmodule

bind tiny_seq_cpu tcpu_checker #(.FW(FW), .DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .halted (halted),
  .state  (st),
  .pc     (pc),
  .ir     (ir),
  .a_val  (ra_data)
);

// File: tb/sim_tiny_seq_cpu.sv
module sim_tiny_seq_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       load_en = 1'b0;
  logic [2:0] load_addr = '0;
  logic [8:0] load_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       halted;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [8:0] prog [8];

  tiny_seq_cpu u0 (
    .clk(clk), .rst(rst), .start(start), .load_en(load_en),
    .load_addr(load_addr), .load_data(load_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .halted(halted)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
      $finish;
    end
  end

  function automatic logic [8:0] ins(int op, int a, int b);
    return {3'(op), 3'(a), 3'(b)};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      load_en = 1'b1; load_addr = 3'(i); load_data = prog[i];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run(output int n);
    @(negedge clk);
    start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
    end while (!halted && n < 5000);
  endtask

  task automatic rd(int sel, output int v);
    @(negedge clk);
    rd_sel = 3'(sel);
    @(negedge clk);
    v = rd_data;
  endtask

  initial begin
    int v, n, loops;
    // R8: reset state and idle without start
    do_reset();
    check("R8 halted after reset", halted, 0);
    for (int i = 0; i < 8; i++) begin
      prog[i] = ins(0, 7, i);
    end
    load_all();
    repeat (20) @(negedge clk);
    check("R8 idle without start", halted, 0);
    for (int i = 0; i < 8; i++) begin
      rd(i, v);
      check("R8 register cleared / R9 read-back", v, 0);
    end

    // R1 R2 R3 R4 R6: multiply loop over all 3-bit factor pairs
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        prog[0] = ins(0, a, 0);
        prog[1] = ins(0, b, 1);
        prog[2] = ins(1, 0, 2);
        prog[3] = ins(2, 1, 1);
        prog[4] = ins(3, 1, 2);
        prog[5] = ins(4, 0, 0);
        prog[6] = ins(4, 0, 0);
        prog[7] = ins(4, 0, 0);
        do_reset();
        load_all();
        run(n);
        loops = (b == 0) ? 256 : b;
        check("R5 stop reached", halted, 1);
        check("R6 edges start->halt", n, 1 + 2 * (3 + 3 * loops));
        rd(2, v);
        check("R2 R4 product", v, (a * loops) % 256);
        rd(0, v);
        check("R1 constant load", v, a);
        rd(1, v);
        check("R3 count reaches zero", v, 0);
      end
    end

    // R7 R3: unused opcodes write nothing; count-down by 3 wraps
    prog[0] = ins(5, 7, 7);
    prog[1] = ins(0, 2, 5);
    prog[2] = ins(2, 5, 3);
    prog[3] = ins(6, 0, 0);
    prog[4] = ins(7, 5, 5);
    prog[5] = ins(4, 0, 0);
    prog[6] = ins(0, 7, 6);
    prog[7] = ins(0, 7, 6);
    do_reset();
    load_all();
    run(n);
    check("R7 edges start->halt", n, 13);
    rd(5, v);
    check("R3 wrap 2-3", v, 255);
    for (int i = 0; i < 8; i++) begin
      if (i != 5) begin
        rd(i, v);
        check("R7 no write by unused opcode", v, 0);
      end
    end

    // R5: start after stop has no effect
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    check("R5 halted sticky", halted, 1);
    rd(6, v);
    check("R5 no execution after stop", v, 0);
    rd(5, v);
    check("R5 register unchanged", v, 255);

    // R4 R6: jump not taken, then taken across 7->0 wrap
    prog[0] = ins(3, 7, 3);
    prog[1] = ins(0, 1, 7);
    prog[2] = ins(3, 7, 7);
    prog[3] = ins(4, 0, 0);
    prog[4] = ins(0, 7, 5);
    prog[5] = ins(0, 7, 5);
    prog[6] = ins(0, 7, 5);
    prog[7] = ins(1, 7, 6);
    do_reset();
    load_all();
    run(n);
    check("R6 wrap edges", n, 13);
    rd(6, v);
    check("R6 wrap reached location 7", v, 1);
    rd(5, v);
    check("R4 jump target skipped 4..6", v, 0);

    // R2: repeated doubling overflows modulo 256
    prog[0] = ins(0, 7, 1);
    for (int i = 1; i < 7; i++) prog[i] = ins(1, 1, 1);
    prog[7] = ins(4, 0, 0);
    do_reset();
    load_all();
    run(n);
    rd(1, v);
    check("R2 accumulate wrap", v, 192);

    // R10: rewrite one word only
    do_reset();
    @(negedge clk);
    load_en = 1'b1; load_addr = 3'd1; load_data = ins(0, 5, 2);
    @(negedge clk);
    load_en = 1'b0;
    run(n);
    rd(1, v);
    check("R10 other words kept", v, 224);
    rd(2, v);
    check("R10 rewritten word", v, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule